// File: doc/BRIEF.md
# Self-Synchronizing Multiplicative Scrambler Pair

This block holds the two halves of a bit-serial randomizer for a serial link. The transmit half mixes each payload bit with two of its own earlier line bits. That feedback makes the line stream look like a fair coin, so a receiver can find enough edges to recover a clock. The receive half holds the last line bits it received in an identical register and mixes each arriving bit with the same two taps. It therefore reproduces the payload with no seed, preamble or alignment word.

The mixing polynomial is 1 + x^-18 + x^-23, and all addition is modulo 2. Each half has its own clock, its own reset and a bit-plus-strobe interface on both sides. A history register moves only on cycles whose input strobe is high. Each output is registered one clock behind its input.

Top module: `selfsync_scrambler_pair`

## Requirements
- R1: While reset is low, both output strobes and both output bits are 0. Both history registers start from all zeros, so for the first 18 valid bits after reset each line bit equals its payload bit.
- R2: For valid payload bit number n, the line bit is d[n] XOR L[n-18] XOR L[n-23]. L is the sequence of earlier line bits, and a line bit from before reset counts as 0.
- R3: For valid received bit number n, the descrambled bit is c[n] XOR c[n-18] XOR c[n-23]. c is the sequence of received line bits since the receive reset, and earlier bits count as 0.
- R4: A cycle with its input strobe low leaves the history unchanged. On the next clock that side's output strobe is 0 and its output bit holds its value.
- R5: Each output strobe equals its input strobe delayed by exactly one clock. The output bit of a valid input appears in that same cycle.
- R6: With the line looped back and no errors, the receive side returns the payload bits exactly, in order, including when the strobes have gaps.
- R7: When the receive side is reset while the transmit side keeps its history, every received bit after the first 23 valid line bits is descrambled correctly.
- R8: One inverted line bit produces exactly three wrong output bits. They are the output for that bit and the outputs 18 and 23 valid bits later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-side clock |
| tx_rst_n | input | 1 | Transmit reset, active low, asserts asynchronously and releases synchronously |
| tx_bit | input | 1 | Payload bit to scramble |
| tx_vld | input | 1 | tx_bit is valid this cycle |
| line_bit | output | 1 | Scrambled bit toward the line |
| line_vld | output | 1 | line_bit is valid |
| rx_clk | input | 1 | Receive-side clock |
| rx_rst_n | input | 1 | Receive reset, active low, asserts asynchronously and releases synchronously |
| rx_line_bit | input | 1 | Bit received from the line |
| rx_line_vld | input | 1 | rx_line_bit is valid this cycle |
| rx_bit | output | 1 | Descrambled payload bit |
| rx_vld | output | 1 | rx_bit is valid |

## Verification
The payload is tried as an alternating pattern, a run of ones and a pseudo-random sequence. The alternating pattern and the run of ones expose a swapped tap or a wrong delay. The pseudo-random stream covers many register states. A second random run with gaps in the strobe shows whether idle cycles disturb either history. One forced line inversion separates correct error spreading (three hits at fixed distances) from a register that feeds the wrong bit back. Resetting only the receive half in the middle of the stream shows that it locks again after 23 bits and needs no help from the sender.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // Which bit enters the history register
  typedef enum logic {
    FEED_LINE_OUT = 1'b0,   // scrambler: own output bit is fed back
    FEED_LINE_IN  = 1'b1    // descrambler: received line bit is fed forward
  } feed_e;

  localparam int unsigned TAP_NEAR_DEF = 18;
  localparam int unsigned TAP_FAR_DEF  = 23;
endpackage

// File: rtl/scr_rst_sync.sv
module scr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/scr_core.sv
module scr_core
  import scr_pkg::*;
#(
  parameter int unsigned TAP_NEAR = TAP_NEAR_DEF,
  parameter int unsigned TAP_FAR  = TAP_FAR_DEF,
  parameter feed_e       MODE     = FEED_LINE_OUT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_vld,
  output logic out_bit,
  output logic out_vld
);
  localparam int unsigned HIST_LEN = TAP_FAR;

  logic [HIST_LEN-1:0] hist_q, hist_d;
  logic                mix;
  logic                feed;
  logic                out_bit_q, out_bit_d;
  logic                out_vld_q, out_vld_d;

  // modulo-2 sum of the input and the two taps (hist_q[0] is newest)
  always_comb begin
    mix = in_bit ^ hist_q[TAP_NEAR-1] ^ hist_q[TAP_FAR-1];
  end

  generate
    if (MODE == FEED_LINE_OUT) begin : g_fb
      always_comb feed = mix;
    end else begin : g_ff
      always_comb feed = in_bit;
    end
  endgenerate

  always_comb begin
    hist_d    = hist_q;
    out_bit_d = out_bit_q;
    out_vld_d = in_vld;
    if (in_vld) begin
      hist_d    = {hist_q[HIST_LEN-2:0], feed};
      out_bit_d = mix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      out_bit_q <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      hist_q    <= hist_d;
      out_bit_q <= out_bit_d;
      out_vld_q <= out_vld_d;
    end
  end

  assign out_bit = out_bit_q;
  assign out_vld = out_vld_q;
endmodule

// File: rtl/selfsync_scrambler_pair.sv
module selfsync_scrambler_pair
  import scr_pkg::*;
#(
  parameter int unsigned TAP_NEAR    = TAP_NEAR_DEF,
  parameter int unsigned TAP_FAR     = TAP_FAR_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic tx_clk,
  input  logic tx_rst_n,
  input  logic tx_bit,
  input  logic tx_vld,
  output logic line_bit,
  output logic line_vld,
  input  logic rx_clk,
  input  logic rx_rst_n,
  input  logic rx_line_bit,
  input  logic rx_line_vld,
  output logic rx_bit,
  output logic rx_vld
);
  logic tx_rst_s;
  logic rx_rst_s;

  scr_rst_sync #(.STAGES(SYNC_STAGES)) u_tx_rst (
    .clk(tx_clk), .rst_n_in(tx_rst_n), .rst_n_out(tx_rst_s));

  scr_rst_sync #(.STAGES(SYNC_STAGES)) u_rx_rst (
    .clk(rx_clk), .rst_n_in(rx_rst_n), .rst_n_out(rx_rst_s));

  scr_core #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR), .MODE(FEED_LINE_OUT)) u_scr (
    .clk(tx_clk), .rst_n(tx_rst_s), .in_bit(tx_bit), .in_vld(tx_vld),
    .out_bit(line_bit), .out_vld(line_vld));

  scr_core #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR), .MODE(FEED_LINE_IN)) u_dscr (
    .clk(rx_clk), .rst_n(rx_rst_s), .in_bit(rx_line_bit), .in_vld(rx_line_vld),
    .out_bit(rx_bit), .out_vld(rx_vld));
endmodule

// File: rtl/scr_pair_chk.sv
module scr_pair_chk #(
  parameter int unsigned TAP_NEAR = 18
) (
  input logic tx_clk,
  input logic rx_clk,
  input logic tx_rst_s,
  input logic rx_rst_s,
  input logic tx_bit,
  input logic tx_vld,
  input logic line_bit,
  input logic line_vld,
  input logic rx_line_vld,
  input logic rx_bit,
  input logic rx_vld
);
  logic [5:0] fill_q;

  always_ff @(posedge tx_clk or negedge tx_rst_s) begin
    if (!tx_rst_s)                             fill_q <= '0;
    else if (tx_vld && fill_q != 6'd63)        fill_q <= fill_q + 6'd1;
  end

  AST_TX_VLD_LAG: assert property (@(posedge tx_clk) disable iff (!tx_rst_s)
    tx_vld |=> line_vld);  // R5
  AST_RX_VLD_LAG: assert property (@(posedge rx_clk) disable iff (!rx_rst_s)
    rx_line_vld |=> rx_vld);  // R5
  AST_TX_IDLE_HOLD: assert property (@(posedge tx_clk) disable iff (!tx_rst_s)
    !tx_vld |=> (!line_vld && $stable(line_bit)));  // R4
  AST_RX_IDLE_HOLD: assert property (@(posedge rx_clk) disable iff (!rx_rst_s)
    !rx_line_vld |=> (!rx_vld && $stable(rx_bit)));  // R4
  AST_TX_EARLY_PASS: assert property (@(posedge tx_clk) disable iff (!tx_rst_s)
    (tx_vld && fill_q < 6'(TAP_NEAR)) |=> (line_bit == $past(tx_bit)));  // R1
endmodule

bind selfsync_scrambler_pair scr_pair_chk #(.TAP_NEAR(TAP_NEAR)) u_chk (
  .tx_clk(tx_clk), .rx_clk(rx_clk), .tx_rst_s(tx_rst_s), .rx_rst_s(rx_rst_s),
  .tx_bit(tx_bit), .tx_vld(tx_vld), .line_bit(line_bit), .line_vld(line_vld),
  .rx_line_vld(rx_line_vld), .rx_bit(rx_bit), .rx_vld(rx_vld));

// File: tb/selfsync_scrambler_pair_test.sv
module selfsync_scrambler_pair_test;
  logic clk = 1'b0;
  logic tx_rst_n, rx_rst_n, tx_bit, tx_vld, flip;
  logic line_bit, line_vld, rx_bit, rx_vld, rx_line_bit;

  always #2 clk = ~clk;  // 250 MHz

  assign rx_line_bit = line_bit ^ flip;

  selfsync_scrambler_pair uut (
    .tx_clk(clk), .tx_rst_n(tx_rst_n), .tx_bit(tx_bit), .tx_vld(tx_vld),
    .line_bit(line_bit), .line_vld(line_vld),
    .rx_clk(clk), .rx_rst_n(rx_rst_n), .rx_line_bit(rx_line_bit),
    .rx_line_vld(line_vld), .rx_bit(rx_bit), .rx_vld(rx_vld));

  int total = 0, bad = 0, mism = 0, rx_cnt = 0, skip = 0;
  bit done = 0;
  bit txq[$], rxq[$], dq[$];
  logic exp_line = 0, exp_lvld = 0, exp_rx = 0, exp_rvld = 0, exp_data = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic bit tap(ref bit q[$], input int k);
    return (q.size() >= k) ? q[q.size()-k] : 1'b0;
  endfunction

  function automatic bit rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[16];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the next posedge, compare at next negedge
  task automatic cyc(bit d, bit v, bit f, string tag);
    bit nb, lb;
    tx_bit = d; tx_vld = v; flip = f;
    if (!rx_rst_n) begin
      exp_rx = 0; exp_rvld = 0; rxq.delete();
    end else if (line_vld) begin
      nb = line_bit ^ f;
      exp_rx = nb ^ tap(rxq, 18) ^ tap(rxq, 23);  // R3
      rxq.push_back(nb);
      if (rxq.size() > 23) void'(rxq.pop_front());
      exp_data = dq.pop_front();
      exp_rvld = 1;
    end else exp_rvld = 0;
    if (v) begin
      lb = d ^ tap(txq, 18) ^ tap(txq, 23);  // R2
      exp_line = lb;
      txq.push_back(lb);
      if (txq.size() > 23) void'(txq.pop_front());
      dq.push_back(d);
      exp_lvld = 1;
    end else exp_lvld = 0;
    @(negedge clk);
    chk({tag, " line_bit R2"}, line_bit, exp_line);
    chk({tag, " line_vld R5"}, line_vld, exp_lvld);
    chk({tag, " rx_bit R3"}, rx_bit, exp_rx);
    chk({tag, " rx_vld R5"}, rx_vld, exp_rvld);
    if (rx_vld === 1'b1) begin
      if (rx_cnt >= skip && rx_bit !== exp_data) mism++;
      rx_cnt++;
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    tx_rst_n = 0; rx_rst_n = 0; tx_bit = 0; tx_vld = 0; flip = 0;
    repeat (3) @(negedge clk);
    chk("reset line_vld R1", line_vld, 0);
    chk("reset rx_vld R1", rx_vld, 0);
    chk("reset line_bit R1", line_bit, 0);
    chk("reset rx_bit R1", rx_bit, 0);
    tx_rst_n = 1; rx_rst_n = 1;
    idle(4, "R4 post-reset idle");

    // first 18 bits pass through unchanged (zero history), R1 via model and R2
    mism = 0; rx_cnt = 0; skip = 0;
    for (int i = 0; i < 40; i++) cyc(i[0], 1, 0, "alt R1");
    idle(3, "alt drain R4");
    chk_int("alternating loopback R6", mism, 0);

    mism = 0;
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, "ones R2");
    idle(3, "ones drain R4");
    chk_int("all-ones loopback R6", mism, 0);

    mism = 0;
    for (int i = 0; i < 200; i++) cyc(rnd(), 1, 0, "random R3");
    idle(3, "random drain R4");
    chk_int("random loopback R6", mism, 0);

    mism = 0;
    for (int i = 0; i < 200; i++) cyc(rnd(), rnd(), 0, "gaps R4");
    idle(3, "gaps drain R4");
    chk_int("gapped loopback R6 R4", mism, 0);

    // single line error: inverted on one valid line bit
    mism = 0;
    for (int i = 0; i < 70; i++) cyc(rnd(), 1, (i == 30), "error R8");
    idle(3, "error drain R4");
    chk_int("single error spreads to three R8", mism, 3);

    // receive-only reset mid-stream
    rx_rst_n = 0;
    idle(2, "rx reset R7");
    rx_rst_n = 1;
    idle(4, "rx release R7");
    mism = 0; rx_cnt = 0; skip = 23;
    for (int i = 0; i < 100; i++) cyc(rnd(), 1, 0, "relock R7");
    idle(3, "relock drain R7");
    chk_int("relock after 23 bits R7", mism, 0);
    chk_int("relock output count R7", rx_cnt, 100);

    done = 1;
    summary();
  end
endmodule